// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block controls a group of general-purpose pins (eight by default) through a small synchronous register interface. Software writes output levels and enables. It also chooses pull resistors and reads back the pin levels. Three registers hold this state: a data word, an enable word and a pull word. Each word packs two per-pin fields side by side. For every pin the block drives an output level, a tri-state enable and pull controls toward a pad model. It also samples the pad level back through a two-flop synchronizer.

Each pin also has a function-select input. When it is set, an on-chip peripheral owns the pin. The peripheral's own output level and enable reach the pad, and every GPIO control of that pin is bypassed: data, enables and pull. The synchronized pad level goes to the peripheral without input gating. The read port is combinational and uses a word address with a single write strobe.

Top module: `gpio_port`

## Requirements
- R1: After reset every field of the three registers reads 0, every `pad_oe` bit is 0 and every `pull_en` bit is 0.
- R2: Address 0 (data word): bits 15:8 are the output-data field, writable and read back. Bits 7:0 are the input field, and writes to them are ignored.
- R3: Address 1 (enable word): bits 15:8 are the input-enable field and bits 7:0 the output-enable field. Both are writable and read back.
- R4: Address 2 (pull word): bits 15:8 select the pull direction (1 = up, 0 = down) and bits 7:0 enable the pull. Both are writable and read back.
- R5: For a GPIO pin (function select 0) with output enable 1, `pad_oe` is 1 and `pad_out` equals its output-data bit. With output enable 0, `pad_oe` is 0. Output data written while the output is disabled is kept and appears once the output is enabled.
- R6: A GPIO pin with input enable 0 reads 0 in data bit 7:0. With input enable 1 the bit shows the pad level. A pad change becomes visible after the second rising clock edge and not after the first.
- R7: With both input and output enabled, the input bit returns the level the block itself drives onto the pad.
- R8: For a pin with function select 1, `pad_out` and `pad_oe` follow `per_out` and `per_oe`, whatever the GPIO registers hold. Its input bit reads 0.
- R9: `pull_en` is 1 only when the pull-enable bit is 1, the GPIO output enable is 0 and the function select is 0. `pull_up` is `pull_en` AND the direction bit.
- R10: Address 3 reads as 0, and a write to it changes no register.
- R11: `per_in` shows the pad level after two rising clock edges, regardless of input enable or function select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data |
| func_sel | input | 8 | Per-pin peripheral ownership (1 = peripheral) |
| per_out | input | 8 | Peripheral output levels |
| per_oe | input | 8 | Peripheral output enables |
| per_in | output | 8 | Synchronized pad levels toward peripherals |
| pad_in | input | 8 | Pad levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad drive enables (0 = high impedance) |
| pull_en | output | 8 | Pull resistor enable |
| pull_up | output | 8 | Pull direction (1 = up) |

## Verification
The bench attacks the byte split of each word. A design that let writes land in the read-only input byte, or swapped the two enable bytes, would read back wrong words or drive the wrong pins. It sets output data while drive is off and then turns drive on. A design that dropped that data, or drove the pad early, would show the wrong pad levels. It counts synchronizer edges exactly, so one flop too few or too many shows up as an early or late read. It also mixes peripheral and GPIO pins in one port: leaking GPIO drive, pulls or input bits onto peripheral pins gives wrong nibbles. A pull left on under an active driver gives a wrong `pull_en`.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      SEL_DATA = 2'd0,
      SEL_EN   = 2'd1,
      SEL_PULL = 2'd2,
      SEL_NONE = 2'd3
   } gpio_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int unsigned NPINS = 8,
   localparam int unsigned REG_W = 2 * NPINS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic [NPINS-1:0]  in_view,
   output logic [REG_W-1:0]  rdata,
   output logic [NPINS-1:0]  dout_q,
   output logic [NPINS-1:0]  ien_q,
   output logic [NPINS-1:0]  oen_q,
   output logic [NPINS-1:0]  pdir_q,
   output logic [NPINS-1:0]  pen_q
);
   gpio_sel_e sel;
   assign sel = gpio_sel_e'(addr);

   logic [NPINS-1:0] hi_byte, lo_byte;
   assign hi_byte = wdata[REG_W-1:NPINS];
   assign lo_byte = wdata[NPINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         ien_q  <= '0;
         oen_q  <= '0;
         pdir_q <= '0;
         pen_q  <= '0;
      end else if (wr_en) begin
         unique case (sel)
            SEL_DATA: dout_q <= hi_byte;
            SEL_EN: begin
               ien_q <= hi_byte;
               oen_q <= lo_byte;
            end
            SEL_PULL: begin
               pdir_q <= hi_byte;
               pen_q  <= lo_byte;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (sel)
         SEL_DATA: rdata = {dout_q, in_view};
         SEL_EN:   rdata = {ien_q, oen_q};
         SEL_PULL: rdata = {pdir_q, pen_q};
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_insync.sv
module gpio_insync #(
   parameter int unsigned NPINS  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] d,
   output logic [NPINS-1:0] q
);
   logic [STAGES-1:0][NPINS-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
   parameter int unsigned NPINS = 8
) (
   input  logic [NPINS-1:0] func_sel,
   input  logic [NPINS-1:0] dout,
   input  logic [NPINS-1:0] ien,
   input  logic [NPINS-1:0] oen,
   input  logic [NPINS-1:0] pdir,
   input  logic [NPINS-1:0] pen,
   input  logic [NPINS-1:0] per_out,
   input  logic [NPINS-1:0] per_oe,
   input  logic [NPINS-1:0] synced,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe,
   output logic [NPINS-1:0] pull_en,
   output logic [NPINS-1:0] pull_up,
   output logic [NPINS-1:0] in_view
);
   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic gpio_own, gpio_pull;
      assign gpio_own  = ~func_sel[i];
      assign gpio_pull = gpio_own & pen[i] & ~oen[i];

      assign pad_out[i] = gpio_own ? dout[i] : per_out[i];
      assign pad_oe[i]  = gpio_own ? oen[i]  : per_oe[i];
      assign pull_en[i] = gpio_pull;
      assign pull_up[i] = gpio_pull & pdir[i];
      assign in_view[i] = gpio_own & ien[i] & synced[i];
   end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_pkg::*;
#(
   parameter int unsigned NPINS       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned REG_W      = 2 * NPINS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   input  logic [NPINS-1:0]  func_sel,
   input  logic [NPINS-1:0]  per_out,
   input  logic [NPINS-1:0]  per_oe,
   output logic [NPINS-1:0]  per_in,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  pull_en,
   output logic [NPINS-1:0]  pull_up
);
   if (NPINS < 1 || NPINS > 16) begin : g_bad_npins
      $error("gpio_port: NPINS must lie in 1..16");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("gpio_port: SYNC_STAGES must lie in 2..4");
   end

   logic [NPINS-1:0] dout_w, ien_w, oen_w, pdir_w, pen_w;
   logic [NPINS-1:0] synced_w, in_view_w;

   gpio_regs #(.NPINS(NPINS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .in_view (in_view_w),
      .rdata   (rdata),
      .dout_q  (dout_w),
      .ien_q   (ien_w),
      .oen_q   (oen_w),
      .pdir_q  (pdir_w),
      .pen_q   (pen_w)
   );

   gpio_insync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (synced_w)
   );

   gpio_pinmux #(.NPINS(NPINS)) u_mux (
      .func_sel (func_sel),
      .dout     (dout_w),
      .ien      (ien_w),
      .oen      (oen_w),
      .pdir     (pdir_w),
      .pen      (pen_w),
      .per_out  (per_out),
      .per_oe   (per_oe),
      .synced   (synced_w),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe),
      .pull_en  (pull_en),
      .pull_up  (pull_up),
      .in_view  (in_view_w)
   );

   assign per_in = synced_w;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int unsigned NPINS       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [1:0]         addr,
   input logic [2*NPINS-1:0] wdata,
   input logic [2*NPINS-1:0] rdata,
   input logic [NPINS-1:0]   func_sel,
   input logic [NPINS-1:0]   per_out,
   input logic [NPINS-1:0]   per_oe,
   input logic [NPINS-1:0]   per_in,
   input logic [NPINS-1:0]   pad_in,
   input logic [NPINS-1:0]   pad_oe,
   input logic [NPINS-1:0]   pad_out,
   input logic [NPINS-1:0]   pull_en,
   input logic [NPINS-1:0]   pull_up,
   input logic [NPINS-1:0]   dout_w,
   input logic [NPINS-1:0]   ien_w
);
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd0) |=> dout_w == $past(wdata[2*NPINS-1:NPINS])); // R2
   AST_INPUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 2'd0) |-> (rdata[NPINS-1:0] & ~ien_w) == '0); // R6
   AST_PERIPH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe ^ per_oe) & func_sel) == '0 && ((pad_out ^ per_out) & func_sel) == '0); // R8
   AST_PERIPH_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 2'd0) |-> (rdata[NPINS-1:0] & func_sel) == '0); // R8
   AST_NO_PULL_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_en & pad_oe & ~func_sel) == '0 && (pull_up & ~pull_en) == '0); // R9
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 2'd3) |-> rdata == '0); // R10
   if (SYNC_STAGES == 2) begin : g_sync2
      AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst == 2'd3) |-> per_in == $past(pad_in, 2)); // R11
   end
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .rdata(rdata), .func_sel(func_sel), .per_out(per_out), .per_oe(per_oe),
   .per_in(per_in), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
   .pull_en(pull_en), .pull_up(pull_up), .dout_w(dout_w), .ien_w(ien_w)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [7:0]  func_sel = '0, per_out = '0, per_oe = '0, per_in;
   logic [7:0]  pad_in, pad_out, pad_oe, pull_en, pull_up;
   logic [7:0]  ext = '0;
   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   // pad model: a driven pin shows its own level, otherwise the external level
   assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

   gpio_port dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .func_sel(func_sel), .per_out(per_out), .per_oe(per_oe),
      .per_in(per_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .pull_en(pull_en), .pull_up(pull_up)
   );

   // {addr, write data, expected read-back}
   localparam logic [33:0] VEC [8] = '{
      {2'd0, 16'hA5FF, 16'hA500},   // R2
      {2'd0, 16'h3C0F, 16'h3C00},   // R2
      {2'd1, 16'h1234, 16'h1234},   // R3
      {2'd1, 16'h8001, 16'h8001},   // R3
      {2'd2, 16'hF00F, 16'hF00F},   // R4
      {2'd2, 16'h0FF0, 16'h0FF0},   // R4
      {2'd3, 16'hFFFF, 16'h0000},   // R10
      {2'd0, 16'h0000, 16'h0000}    // R2
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      addr = a;
      #0.5;
      d = rdata;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [15:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), r);
         check("R1", r, 16'h0000);
      end
      check("R1 pad_oe", {8'h0, pad_oe}, 16'h0);
      check("R1 pull_en", {8'h0, pull_en}, 16'h0);

      // vector walk, input disabled so low byte of data reads 0
      for (int v = 0; v < 8; v++) begin
         wr(VEC[v][33:32], VEC[v][31:16]);
         rd(VEC[v][33:32], r);
         check("R2/R3/R4/R10 table", r, VEC[v][15:0]);
      end
      // R10: address 3 write left the pull word intact
      rd(2'd2, r);
      check("R10 pull kept", r, 16'h0FF0);
      wr(2'd2, 16'h0000);

      // R5: data kept while drive off
      wr(2'd1, 16'h0000);
      wr(2'd0, 16'hA500);
      check("R5 oe off", {8'h0, pad_oe}, 16'h0000);
      wr(2'd1, 16'h00FF);
      check("R5 oe on", {pad_oe, pad_out}, 16'hFFA5);

      // R6: gating and two-edge latency
      wr(2'd1, 16'h0000);
      ext = 8'hFF;
      repeat (3) @(negedge clk);
      rd(2'd0, r);
      check("R6 disabled reads 0", {8'h0, r[7:0]}, 16'h0000);
      wr(2'd1, 16'hFF00);
      rd(2'd0, r);
      check("R6 enabled", {8'h0, r[7:0]}, 16'h00FF);
      ext = 8'h3C;
      @(negedge clk);
      rd(2'd0, r);
      check("R6 one edge", {8'h0, r[7:0]}, 16'h00FF);
      @(negedge clk);
      rd(2'd0, r);
      check("R6 two edges", {8'h0, r[7:0]}, 16'h003C);

      // R11: peripheral sees pad even with input disabled
      wr(2'd1, 16'h0000);
      ext = 8'h96;
      repeat (2) @(negedge clk);
      check("R11 per_in", {8'h0, per_in}, 16'h0096);
      rd(2'd0, r);
      check("R11 gpio gated", {8'h0, r[7:0]}, 16'h0000);

      // R7: loopback of own drive
      ext = 8'h00;
      wr(2'd0, 16'h5A00);
      wr(2'd1, 16'hFFFF);
      repeat (2) @(negedge clk);
      rd(2'd0, r);
      check("R7 loopback", {8'h0, r[7:0]}, 16'h005A);

      // R8: low nibble owned by a peripheral
      func_sel = 8'h0F; per_out = 8'h06; per_oe = 8'h03;
      repeat (2) @(negedge clk);
      check("R8 pad_out", {8'h0, pad_out}, 16'h0056);
      check("R8 pad_oe", {8'h0, pad_oe}, 16'h00F3);
      rd(2'd0, r);
      check("R8 input masked", {8'h0, r[7:0]}, 16'h0050);

      // R9: pulls
      func_sel = 8'h00;
      wr(2'd1, 16'h000F);
      wr(2'd2, 16'hF0CC);
      check("R9 pull", {pull_en, pull_up}, 16'hC0C0);
      func_sel = 8'h40;
      #0.5;
      check("R9 pull periph", {pull_en, pull_up}, 16'h8080);
      wr(2'd2, 16'h00CC);
      check("R9 pull down", {pull_en, pull_up}, 16'h8000);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule